// File: doc/BRIEF.md
# Flat Address Aperture Resolver

This block takes one vector memory access issued with flat addressing and decides which memory segment it targets. An access carries a lane-active mask and one address per lane. Three configured address windows (local shared memory, per-lane scratch, and a virtual-memory window that is not supported) are tested against the lowest active lane. That lane alone picks the segment. Every other active lane must then agree with it.

Once the segment is known, each active lane's address is rewritten into that segment's own address space. Local shared accesses become offsets from the window base. Scratch accesses gain a per-lane stride plus wave and hidden bases. Global accesses pass through unchanged. The result names the segment and the execution pipe that should carry the access, or it reports exactly one error class. The block is a two-stage pipeline with a valid/ready handshake on both sides. Window and scratch configuration must be held stable while accesses are in flight.

Top module: `flat_aperture_resolver`

## Requirements
- R1: An access accepted at a rising edge (req_valid and req_ready both high) shows res_valid high after the next rising edge when res_ready is high. req_ready equals the inverse of "pipeline full and downstream stalled". While res_valid is high and res_ready is low, every result output holds its value.
- R2: The segment is chosen from the lowest-numbered active lane alone. Its address is tested in this order: the local window (lds_win_lo ≤ a ≤ lds_win_hi) gives group, then the scratch window gives private, then the virtual-memory window gives an error, then the hole test gives an error, and otherwise the access is global. res_seg encodes 2'b00 none, 2'b01 global, 2'b10 group, 2'b11 private.
- R3: For group, each active lane's output is its address minus lds_win_lo.
- R4: For private, each active lane's output is address + lane × scr_lane_bytes + scr_wave_off + scr_hidden_base − scr_mem_base, computed modulo 2^64.
- R5: Global outputs equal the inputs. res_unit is 0 (global pipe) for global and 1 (local pipe) for group and private.
- R6: An all-zero mask sets res_err bit 0 and does not resolve a segment.
- R7: A deciding lane inside the virtual-memory window sets res_err bit 1.
- R8: A deciding lane whose bits [63:47] are neither all zeros nor all ones sets res_err bit 2. Canonical upper addresses (all ones) are global.
- R9: An active lane whose class differs from the deciding lane's sets res_err bit 3. For a global decision, this covers any other lane inside a window or in the hole.
- R10: A group access where any active lane's offset is ≥ lds_bytes sets res_err bit 4.
- R11: res_err has at most one bit set, with priority empty > vm > hole > straddle > lds range. When any bit is set, res_seg is none, res_unit is 0 and all addresses are zero.
- R12: Inactive lanes take no part in classification or checks, and their output address is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access offered |
| req_ready | output | 1 | Access accepted this edge when valid |
| req_mask | input | LANES | Lane-active mask |
| req_addr | input | LANES*ADDR_W | Per-lane flat addresses, lane i at [i*ADDR_W +: ADDR_W] |
| lds_win_lo | input | ADDR_W | Local shared window base |
| lds_win_hi | input | ADDR_W | Local shared window limit (inclusive) |
| lds_bytes | input | ADDR_W | Local shared memory size |
| prv_win_lo | input | ADDR_W | Scratch window base |
| prv_win_hi | input | ADDR_W | Scratch window limit (inclusive) |
| vm_win_lo | input | ADDR_W | Unsupported virtual-memory window base |
| vm_win_hi | input | ADDR_W | Unsupported virtual-memory window limit |
| scr_lane_bytes | input | OFS_W | Scratch bytes per lane |
| scr_wave_off | input | OFS_W | Wave scratch offset |
| scr_hidden_base | input | ADDR_W | Hidden private base |
| scr_mem_base | input | ADDR_W | Scratch memory base subtracted |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result consumed this edge when valid |
| res_addr | output | LANES*ADDR_W | Segment addresses, same lane layout |
| res_seg | output | 2 | Segment code |
| res_unit | output | 1 | 0 global pipe, 1 local pipe |
| res_err | output | 5 | One-hot error class |

## Verification
A wrong deciding lane or a broken priority shows up as the wrong res_seg or an extra straddle bit on the very result of that access, two edges after acceptance. A stale or corrupted pipeline register shows up either as an output that changes during a stall or as a scoreboard mismatch on the next handshake. Per-lane transform faults show up as a single wrong lane address. The bench names the first such lane. Masks with inactive lanes that hold hostile addresses expose any lane that leaks into classification or output.

// File: rtl/flat_res_pkg.sv
// Shared codes for the flat aperture resolver.
// Assumes nothing; pure type and constant definitions.
package flat_res_pkg;

    typedef enum logic [1:0] {
        SEG_NONE    = 2'b00,
        SEG_GLOBAL  = 2'b01,
        SEG_GROUP   = 2'b10,
        SEG_PRIVATE = 2'b11
    } seg_e;

    typedef enum logic [2:0] {
        CAT_GLOBAL  = 3'd0,
        CAT_GROUP   = 3'd1,
        CAT_PRIVATE = 3'd2,
        CAT_VM      = 3'd3,
        CAT_HOLE    = 3'd4
    } cat_e;

    localparam int ERR_W        = 5;
    localparam int ERR_EMPTY    = 0;
    localparam int ERR_VM       = 1;
    localparam int ERR_HOLE     = 2;
    localparam int ERR_STRADDLE = 3;
    localparam int ERR_LDSRANGE = 4;

    localparam logic UNIT_GLOBAL = 1'b0;
    localparam logic UNIT_LOCAL  = 1'b1;

endpackage

// File: rtl/flat_lane_classify.sv
// Classifies one address against the three windows and the hole test.
// Assumes inclusive window bounds; the order of tests sets priority.
module flat_lane_classify
    import flat_res_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int HOLE_LSB = 47
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] lds_lo,
    input  logic [ADDR_W-1:0] lds_hi,
    input  logic [ADDR_W-1:0] prv_lo,
    input  logic [ADDR_W-1:0] prv_hi,
    input  logic [ADDR_W-1:0] vm_lo,
    input  logic [ADDR_W-1:0] vm_hi,
    output cat_e              cat
);
    localparam int HOLE_W = ADDR_W - HOLE_LSB;

    logic [HOLE_W-1:0] upper;
    logic in_lds, in_prv, in_vm, in_hole;

    assign upper   = addr[ADDR_W-1:HOLE_LSB];
    assign in_lds  = (addr >= lds_lo) && (addr <= lds_hi);
    assign in_prv  = (addr >= prv_lo) && (addr <= prv_hi);
    assign in_vm   = (addr >= vm_lo)  && (addr <= vm_hi);
    assign in_hole = (upper != '0) && (upper != '1);

    // Pick the class by fixed test priority.
    always_comb begin
        if (in_lds)       cat = CAT_GROUP;
        else if (in_prv)  cat = CAT_PRIVATE;
        else if (in_vm)   cat = CAT_VM;
        else if (in_hole) cat = CAT_HOLE;
        else              cat = CAT_GLOBAL;
    end

endmodule

// File: rtl/flat_classify_stage.sv
// Stage one: per-lane classification, deciding-lane pick, agreement
// check and error choice, registered behind a valid/ready slot.
// Assumes windows are stable while an access sits in this stage.
module flat_classify_stage
    import flat_res_pkg::*;
#(
    parameter int LANES    = 64,
    parameter int ADDR_W   = 64,
    parameter int HOLE_LSB = 47
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [LANES-1:0]        in_mask,
    input  logic [LANES*ADDR_W-1:0] in_addr,
    input  logic [ADDR_W-1:0]       lds_lo,
    input  logic [ADDR_W-1:0]       lds_hi,
    input  logic [ADDR_W-1:0]       prv_lo,
    input  logic [ADDR_W-1:0]       prv_hi,
    input  logic [ADDR_W-1:0]       vm_lo,
    input  logic [ADDR_W-1:0]       vm_hi,
    input  logic                    down_ready,
    output logic                    s1_valid,
    output logic [LANES-1:0]        s1_mask,
    output logic [LANES*ADDR_W-1:0] s1_addr,
    output seg_e                    s1_seg,
    output logic [ERR_W-1:0]        s1_err
);
    cat_e             lane_cat [LANES];
    logic             found;
    cat_e             lead;
    logic             straddle;
    seg_e             seg_n;
    logic [ERR_W-1:0] err_n;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        flat_lane_classify #(
            .ADDR_W  (ADDR_W),
            .HOLE_LSB(HOLE_LSB)
        ) u_cls (
            .addr  (in_addr[g*ADDR_W +: ADDR_W]),
            .lds_lo(lds_lo),
            .lds_hi(lds_hi),
            .prv_lo(prv_lo),
            .prv_hi(prv_hi),
            .vm_lo (vm_lo),
            .vm_hi (vm_hi),
            .cat   (lane_cat[g])
        );
    end

    // Take the class of the lowest active lane.
    always_comb begin
        found = 1'b0;
        lead  = CAT_GLOBAL;
        for (int i = 0; i < LANES; i++) begin
            if (in_mask[i] && !found) begin
                found = 1'b1;
                lead  = lane_cat[i];
            end
        end
    end

    // Flag any active lane whose class differs from the deciding one.
    always_comb begin
        straddle = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (in_mask[i] && (lane_cat[i] != lead)) straddle = 1'b1;
        end
    end

    // Choose a single error class by priority, else the segment.
    always_comb begin
        err_n = '0;
        seg_n = SEG_NONE;
        if (!found)                err_n[ERR_EMPTY]    = 1'b1;
        else if (lead == CAT_VM)   err_n[ERR_VM]       = 1'b1;
        else if (lead == CAT_HOLE) err_n[ERR_HOLE]     = 1'b1;
        else if (straddle)         err_n[ERR_STRADDLE] = 1'b1;
        else begin
            case (lead)
                CAT_GROUP:   seg_n = SEG_GROUP;
                CAT_PRIVATE: seg_n = SEG_PRIVATE;
                default:     seg_n = SEG_GLOBAL;
            endcase
        end
    end

    assign in_ready = !s1_valid || down_ready;

    // Slot occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n)        s1_valid <= 1'b0;
        else if (in_ready) s1_valid <= in_valid;
    end

    // Slot payload, loaded only on acceptance.
    always_ff @(posedge clk) begin
        if (in_ready && in_valid) begin
            s1_mask <= in_mask;
            s1_addr <= in_addr;
            s1_seg  <= seg_n;
            s1_err  <= err_n;
        end
    end

    assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> s1_valid);

    assert_hold_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid && !down_ready |=> s1_valid && $stable(s1_mask) && $stable(s1_seg));

    assert_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid && (s1_mask == '0) |-> s1_err[ERR_EMPTY] && (s1_seg == SEG_NONE));

    assert_err_kills_seg_R11: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid && (s1_err != '0) |-> (s1_seg == SEG_NONE));

endmodule

// File: rtl/flat_xform_stage.sv
// Stage two: per-lane address rewrite, local range check, error
// masking and the result register with downstream handshake.
// Assumes scratch and local parameters are stable while in flight.
module flat_xform_stage
    import flat_res_pkg::*;
#(
    parameter int LANES  = 64,
    parameter int ADDR_W = 64,
    parameter int OFS_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    s1_valid,
    input  logic [LANES-1:0]        s1_mask,
    input  logic [LANES*ADDR_W-1:0] s1_addr,
    input  seg_e                    s1_seg,
    input  logic [ERR_W-1:0]        s1_err,
    input  logic [ADDR_W-1:0]       lds_lo,
    input  logic [ADDR_W-1:0]       lds_bytes,
    input  logic [OFS_W-1:0]        lane_bytes,
    input  logic [OFS_W-1:0]        wave_off,
    input  logic [ADDR_W-1:0]       hidden_base,
    input  logic [ADDR_W-1:0]       mem_base,
    output logic                    up_ready,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [LANES*ADDR_W-1:0] out_addr,
    output seg_e                    out_seg,
    output logic                    out_unit,
    output logic [ERR_W-1:0]        out_err
);
    logic [ADDR_W-1:0]       prv_bias;
    logic [ADDR_W-1:0]       stride;
    logic [ADDR_W-1:0]       lane_out [LANES];
    logic [LANES-1:0]        lane_bad;
    logic [ERR_W-1:0]        err_n;
    logic                    kill;
    logic [LANES*ADDR_W-1:0] addr_n;
    seg_e                    seg_n;
    logic [LANES-1:0]        r_mask;

    assign prv_bias = ADDR_W'(wave_off) + hidden_base - mem_base;
    assign stride   = ADDR_W'(lane_bytes);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [ADDR_W-1:0] IDX = ADDR_W'(g);
        logic [ADDR_W-1:0] a_in, grp, prv;
        assign a_in = s1_addr[g*ADDR_W +: ADDR_W];
        assign grp  = a_in - lds_lo;
        assign prv  = a_in + IDX * stride + prv_bias;
        assign lane_bad[g] = s1_mask[g] && (s1_seg == SEG_GROUP) && (grp >= lds_bytes);
        assign lane_out[g] = !s1_mask[g]              ? '0   :
                             (s1_seg == SEG_GROUP)   ? grp  :
                             (s1_seg == SEG_PRIVATE) ? prv  :
                             (s1_seg == SEG_GLOBAL)  ? a_in : '0;
    end

    // Merge the local range error into the stage-one errors.
    always_comb begin
        err_n = s1_err;
        if (|lane_bad) err_n[ERR_LDSRANGE] = 1'b1;
        kill  = |err_n;
        seg_n = kill ? SEG_NONE : s1_seg;
    end

    // Zero all lanes on any error.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            addr_n[i*ADDR_W +: ADDR_W] = kill ? '0 : lane_out[i];
        end
    end

    assign up_ready = !out_valid || out_ready;

    // Result occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n)        out_valid <= 1'b0;
        else if (up_ready) out_valid <= s1_valid;
    end

    // Result payload, loaded when the slot advances.
    always_ff @(posedge clk) begin
        if (up_ready && s1_valid) begin
            out_addr <= addr_n;
            out_seg  <= seg_n;
            out_unit <= (seg_n == SEG_GROUP) || (seg_n == SEG_PRIVATE);
            out_err  <= err_n;
            r_mask   <= s1_mask;
        end
    end

    assert_stall_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr)
                                   && $stable(out_seg) && $stable(out_err));

    assert_err_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot0(out_err));

    assert_err_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_err != '0) |-> (out_seg == SEG_NONE) && (out_addr == '0)
                                         && (out_unit == UNIT_GLOBAL));

    assert_unit_global_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_seg == SEG_GLOBAL) |-> (out_unit == UNIT_GLOBAL));

    assert_unit_local_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && ((out_seg == SEG_GROUP) || (out_seg == SEG_PRIVATE))
            |-> (out_unit == UNIT_LOCAL));

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        assert_idle_lane_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid && !r_mask[g] |-> (out_addr[g*ADDR_W +: ADDR_W] == '0));
    end

endmodule

// File: rtl/flat_aperture_resolver.sv
// Top: resolves a flat vector access to a segment in two stages.
// Assumes windows and scratch parameters are held while accesses are
// in flight; result appears one edge after the access leaves stage one.
module flat_aperture_resolver
    import flat_res_pkg::*;
#(
    parameter int LANES    = 64,
    parameter int ADDR_W   = 64,
    parameter int OFS_W    = 32,
    parameter int HOLE_LSB = 47
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES-1:0]        req_mask,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0]       lds_win_lo,
    input  logic [ADDR_W-1:0]       lds_win_hi,
    input  logic [ADDR_W-1:0]       lds_bytes,
    input  logic [ADDR_W-1:0]       prv_win_lo,
    input  logic [ADDR_W-1:0]       prv_win_hi,
    input  logic [ADDR_W-1:0]       vm_win_lo,
    input  logic [ADDR_W-1:0]       vm_win_hi,
    input  logic [OFS_W-1:0]        scr_lane_bytes,
    input  logic [OFS_W-1:0]        scr_wave_off,
    input  logic [ADDR_W-1:0]       scr_hidden_base,
    input  logic [ADDR_W-1:0]       scr_mem_base,
    output logic                    res_valid,
    input  logic                    res_ready,
    output logic [LANES*ADDR_W-1:0] res_addr,
    output logic [1:0]              res_seg,
    output logic                    res_unit,
    output logic [ERR_W-1:0]        res_err
);
    logic                    s1_valid;
    logic [LANES-1:0]        s1_mask;
    logic [LANES*ADDR_W-1:0] s1_addr;
    seg_e                    s1_seg;
    logic [ERR_W-1:0]        s1_err;
    logic                    s2_ready;
    seg_e                    seg_q;

    flat_classify_stage #(
        .LANES   (LANES),
        .ADDR_W  (ADDR_W),
        .HOLE_LSB(HOLE_LSB)
    ) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_valid),
        .in_ready  (req_ready),
        .in_mask   (req_mask),
        .in_addr   (req_addr),
        .lds_lo    (lds_win_lo),
        .lds_hi    (lds_win_hi),
        .prv_lo    (prv_win_lo),
        .prv_hi    (prv_win_hi),
        .vm_lo     (vm_win_lo),
        .vm_hi     (vm_win_hi),
        .down_ready(s2_ready),
        .s1_valid  (s1_valid),
        .s1_mask   (s1_mask),
        .s1_addr   (s1_addr),
        .s1_seg    (s1_seg),
        .s1_err    (s1_err)
    );

    flat_xform_stage #(
        .LANES (LANES),
        .ADDR_W(ADDR_W),
        .OFS_W (OFS_W)
    ) u_back (
        .clk        (clk),
        .rst_n      (rst_n),
        .s1_valid   (s1_valid),
        .s1_mask    (s1_mask),
        .s1_addr    (s1_addr),
        .s1_seg     (s1_seg),
        .s1_err     (s1_err),
        .lds_lo     (lds_win_lo),
        .lds_bytes  (lds_bytes),
        .lane_bytes (scr_lane_bytes),
        .wave_off   (scr_wave_off),
        .hidden_base(scr_hidden_base),
        .mem_base   (scr_mem_base),
        .up_ready   (s2_ready),
        .out_valid  (res_valid),
        .out_ready  (res_ready),
        .out_addr   (res_addr),
        .out_seg    (seg_q),
        .out_unit   (res_unit),
        .out_err    (res_err)
    );

    assign res_seg = seg_q;

    assert_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> req_ready);

endmodule

// File: tb/test_flat_aperture_resolver.sv
`timescale 1ns/1ps
module test_flat_aperture_resolver;
    localparam int LANES = 64;
    localparam int AW    = 64;
    localparam int FW    = LANES * AW;

    localparam logic [63:0] LDS_LO = 64'h0000_1000_0000_0000;
    localparam logic [63:0] LDS_HI = 64'h0000_1000_0001_FFFF;
    localparam logic [63:0] LDS_SZ = 64'h0000_0000_0001_0000;
    localparam logic [63:0] PRV_LO = 64'h0000_2000_0000_0000;
    localparam logic [63:0] PRV_HI = 64'h0000_2000_FFFF_FFFF;
    localparam logic [63:0] VM_LO  = 64'h0000_3000_0000_0000;
    localparam logic [63:0] VM_HI  = 64'h0000_3000_FFFF_FFFF;
    localparam logic [63:0] HOLE_A = 64'h0001_0000_0000_0000;

    logic clk = 1'b0;
    logic rst_n;
    logic req_valid, req_ready, res_valid, res_ready, res_unit;
    logic [LANES-1:0] req_mask;
    logic [FW-1:0] req_addr, res_addr;
    logic [63:0] lds_win_lo, lds_win_hi, lds_bytes, prv_win_lo, prv_win_hi;
    logic [63:0] vm_win_lo, vm_win_hi, scr_hidden_base, scr_mem_base;
    logic [31:0] scr_lane_bytes, scr_wave_off;
    logic [1:0] res_seg;
    logic [4:0] res_err;

    typedef struct packed {
        logic [FW-1:0] addr;
        logic [1:0]    seg;
        logic          unit;
        logic [4:0]    err;
    } exp_t;

    exp_t  expq[$];
    string tagq[$];
    int    total = 0;
    int    bad   = 0;
    bit    bp_on = 1'b0;
    int    cyc   = 0;

    always #4 clk = ~clk;

    flat_aperture_resolver i_flat_aperture_resolver (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_mask(req_mask), .req_addr(req_addr),
        .lds_win_lo(lds_win_lo), .lds_win_hi(lds_win_hi), .lds_bytes(lds_bytes),
        .prv_win_lo(prv_win_lo), .prv_win_hi(prv_win_hi),
        .vm_win_lo(vm_win_lo), .vm_win_hi(vm_win_hi),
        .scr_lane_bytes(scr_lane_bytes), .scr_wave_off(scr_wave_off),
        .scr_hidden_base(scr_hidden_base), .scr_mem_base(scr_mem_base),
        .res_valid(res_valid), .res_ready(res_ready), .res_addr(res_addr),
        .res_seg(res_seg), .res_unit(res_unit), .res_err(res_err)
    );

    task automatic chk(input bit ok, input string tag, input string what);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s", tag, what);
        end
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Class of one address from the window and hole rules (R2, R8).
    function automatic logic [2:0] cls(input logic [63:0] a);
        if (a >= lds_win_lo && a <= lds_win_hi) return 3'd1;
        if (a >= prv_win_lo && a <= prv_win_hi) return 3'd2;
        if (a >= vm_win_lo && a <= vm_win_hi)   return 3'd3;
        if (a[63:47] != 17'h0 && a[63:47] != 17'h1FFFF) return 3'd4;
        return 3'd0;
    endfunction

    // Expected result from the requirements.
    function automatic exp_t model(input logic [LANES-1:0] m, input logic [FW-1:0] fa);
        exp_t e;
        int first;
        logic [2:0] c;
        logic [4:0] er;
        logic [63:0] a, d;
        e = '0;
        er = '0;
        first = -1;
        c = 3'd0;
        for (int i = LANES - 1; i >= 0; i--) if (m[i]) first = i;
        if (first < 0) er[0] = 1'b1;
        else begin
            c = cls(fa[first*AW +: AW]);
            if (c == 3'd3) er[1] = 1'b1;
            else if (c == 3'd4) er[2] = 1'b1;
            else for (int i = 0; i < LANES; i++)
                if (m[i] && cls(fa[i*AW +: AW]) != c) er[3] = 1'b1;
        end
        if (er == '0) begin
            for (int i = 0; i < LANES; i++) begin
                if (m[i]) begin
                    a = fa[i*AW +: AW];
                    case (c)
                        3'd1: begin
                            d = a - lds_win_lo;
                            if (d >= lds_bytes) er[4] = 1'b1;
                        end
                        3'd2: d = a + 64'(i) * 64'(scr_lane_bytes) + 64'(scr_wave_off)
                                  + scr_hidden_base - scr_mem_base;
                        default: d = a;
                    endcase
                    e.addr[i*AW +: AW] = d;
                end
            end
        end
        if (er != '0) begin
            e.addr = '0;
            e.seg  = 2'b00;
            e.unit = 1'b0;
        end else begin
            e.seg  = (c == 3'd0) ? 2'b01 : (c == 3'd1) ? 2'b10 : 2'b11;
            e.unit = (c != 3'd0);
        end
        e.err = er;
        return e;
    endfunction

    function automatic logic [FW-1:0] fill(input logic [63:0] base, input logic [63:0] step);
        logic [FW-1:0] f;
        for (int i = 0; i < LANES; i++) f[i*AW +: AW] = base + 64'(i) * step;
        return f;
    endfunction

    // Driver: offer one access, push its expected result on acceptance.
    task automatic send(input logic [LANES-1:0] m, input logic [FW-1:0] fa, input string tag);
        @(negedge clk); #1;
        req_mask  = m;
        req_addr  = fa;
        req_valid = 1'b1;
        while (!req_ready) begin
            @(negedge clk); #1;
        end
        expq.push_back(model(m, fa));
        tagq.push_back(tag);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (expq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: pick downstream readiness, check stalls, pop and compare.
    bit          was_stall = 1'b0;
    logic [FW-1:0] held_addr;
    logic [1:0]  held_seg;
    logic [4:0]  held_err;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                res_ready = bp_on ? (($urandom % 3) != 0) : 1'b1;
                if (was_stall)
                    chk(res_valid && res_addr == held_addr && res_seg == held_seg
                        && res_err == held_err, "R1",
                        $sformatf("stall hold: valid=%0d seg=%0d/%0d err=%b/%b",
                                  res_valid, res_seg, held_seg, res_err, held_err));
                was_stall = res_valid && !res_ready;
                held_addr = res_addr;
                held_seg  = res_seg;
                held_err  = res_err;
                if (res_valid && res_ready) begin
                    if (expq.size() == 0) chk(1'b0, "R1", "result with nothing expected, actual 1 expected 0");
                    else begin
                        exp_t  e;
                        string t;
                        int    ml;
                        e  = expq.pop_front();
                        t  = tagq.pop_front();
                        ml = -1;
                        for (int i = LANES - 1; i >= 0; i--)
                            if (res_addr[i*AW +: AW] != e.addr[i*AW +: AW]) ml = i;
                        if (ml < 0) ml = 0;
                        chk(res_addr == e.addr && res_seg == e.seg && res_unit == e.unit
                            && res_err == e.err, t,
                            $sformatf("seg=%0d exp %0d unit=%0d exp %0d err=%b exp %b lane%0d addr=%h exp %h",
                                      res_seg, e.seg, res_unit, e.unit, res_err, e.err, ml,
                                      res_addr[ml*AW +: AW], e.addr[ml*AW +: AW]));
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                chk(1'b0, "R1", "watchdog expired, actual hung expected done");
                finish_up();
            end
        end
    end

    initial begin
        logic [FW-1:0] fa;
        logic [LANES-1:0] m;
        rst_n = 1'b0; req_valid = 1'b0; res_ready = 1'b1;
        req_mask = '0; req_addr = '0;
        lds_win_lo = LDS_LO; lds_win_hi = LDS_HI; lds_bytes = LDS_SZ;
        prv_win_lo = PRV_LO; prv_win_hi = PRV_HI;
        vm_win_lo = VM_LO; vm_win_hi = VM_HI;
        scr_lane_bytes = 32'h100; scr_wave_off = 32'h40;
        scr_hidden_base = 64'h0000_0001_0000_0000; scr_mem_base = 64'h0000_0000_8000_0000;
        repeat (3) @(negedge clk);
        chk(res_valid == 1'b0 && req_ready == 1'b1, "R1",
            $sformatf("reset: valid=%0d ready=%0d expected 0/1", res_valid, req_ready));
        rst_n = 1'b1;

        // R5 global pass-through and R1 latency
        send('1, fill(64'h1000, 8), "R5 global");
        @(negedge clk);
        chk(res_valid == 1'b0, "R1", $sformatf("latency early: valid=%0d expected 0", res_valid));
        @(negedge clk);
        chk(res_valid == 1'b1, "R1", $sformatf("latency: valid=%0d expected 1", res_valid));

        // R3 group
        send('1, fill(LDS_LO, 4), "R3 group");

        // R4 private with hostile inactive lanes (R12)
        fa = fill(PRV_LO, 16);
        for (int i = 1; i < LANES; i += 2) fa[i*AW +: AW] = HOLE_A;
        send({32{2'b01}}, fa, "R4 R12 private");

        // R2 lowest active lane decides
        fa = fill(LDS_LO + 64'h100, 4);
        for (int i = 0; i < 3; i++) fa[i*AW +: AW] = VM_LO;
        send(~64'h7, fa, "R2 lowest lane");

        // R6 empty mask
        send('0, fill(LDS_LO, 4), "R6 empty");

        // R7 virtual-memory window
        fa = fill(64'h2000, 8);
        fa[0 +: AW] = VM_LO + 64'h40;
        send('1, fa, "R7 vm");

        // R8 hole variants and canonical upper
        fa = fill(64'h3000, 8);
        fa[7*AW +: AW] = HOLE_A;
        send(64'h1 << 7, fa, "R8 hole");
        fa[0 +: AW] = 64'h8000_0000_0000_0000;
        send(64'h1, fa, "R8 hole top bit");
        send('1, fill(64'hFFFF_8000_0000_0000, 64), "R8 canonical upper");

        // R9 straddle: global lead with a local lane, and with a hole lane
        fa = fill(64'h2000, 8);
        fa[10*AW +: AW] = LDS_LO;
        send('1, fa, "R9 straddle local");
        fa = fill(64'h2000, 8);
        fa[5*AW +: AW] = HOLE_A;
        send('1, fa, "R9 straddle hole");

        // R10 local range edge
        fa = fill(LDS_LO, 4);
        fa[20*AW +: AW] = LDS_LO + LDS_SZ;
        send('1, fa, "R10 range over");
        fa[20*AW +: AW] = LDS_LO + LDS_SZ - 64'h1;
        send('1, fa, "R10 range edge");

        // R2 priority: scratch window overlapping local window
        drain();
        prv_win_lo = LDS_LO; prv_win_hi = PRV_HI;
        send('1, fill(LDS_LO, 4), "R2 priority local over scratch");
        drain();
        prv_win_lo = PRV_LO;

        // R1 R11 mixed stream under backpressure
        bp_on = 1'b1;
        for (int n = 0; n < 40; n++) begin
            int k;
            k = $urandom % 6;
            m = {$urandom, $urandom};
            if ((n % 9) == 8) m = '0;
            case (k)
                0: fa = fill(64'(($urandom % 4096)) << 12, 8);
                1: fa = fill(LDS_LO + 64'(($urandom % 256)) * 4, 4);
                2: fa = fill(PRV_LO + 64'(($urandom % 256)) * 16, 16);
                3: begin fa = fill(64'h5000, 8); fa[0 +: AW] = VM_LO; end
                4: begin fa = fill(64'h5000, 8); fa[($urandom % LANES)*AW +: AW] = HOLE_A; end
                default: begin fa = fill(LDS_LO, 4); fa[($urandom % LANES)*AW +: AW] = 64'h9000; end
            endcase
            send(m, fa, "R1 R11 stream");
        end
        drain();
        bp_on = 1'b0;
        finish_up();
    end

endmodule